// File: doc/BRIEF.md
# Per-Flow Linked-List Queue Manager

This block keeps one first-in first-out queue per flow number. Every queue draws from one shared pool of buffer slots. Each slot holds a data word and a link to the next slot. A flow's queue is a chain of slots from its head pointer to its tail pointer. The tail slot is always allocated in advance and stays unused until data arrives for it. Slots nobody owns sit on a free stack.

An enqueue writes the word into the flow's tail slot. It pops a fresh slot from the free stack, links the fresh slot behind the tail slot and moves the tail pointer to it. A dequeue reads the flow's head slot and presents its word at the output one cycle later. It advances the head pointer along the link and pushes the old head slot back onto the free stack.

Requests arrive one at a time over two valid/ready channels. A scheduler decides which flow departs and when; that decision is made outside this block.

Top module: `qm_top`

## Requirements
- R1: After reset, every bit of `flow_empty` is 1, `full` is 0, `enq_ready` is 1, and `out_valid` and `deq_err` are both 0.
- R2: Within one flow, dequeued words come out in the order they were enqueued.
- R3: Words enqueued on different flows, in any interleaving, come out only on dequeues of their own flow.
- R4: With NSLOTS slots and NFLOWS flows, the block accepts exactly NSLOTS-NFLOWS enqueues before any dequeue. It then holds `full` at 1 and `enq_ready` at 0.
- R5: A successful dequeue returns its slot to the pool. After a successful dequeue while full, `full` is 0 in the following cycle and one more enqueue is accepted.
- R6: A dequeue accepted on a flow whose `flow_empty` bit is 1 raises `deq_err` for exactly the next cycle. It does not raise `out_valid` and changes no queue.
- R7: When `enq_valid` and `deq_valid` are both 1, `deq_ready` is 0 and only the enqueue is taken in that cycle.
- R8: `out_valid` is 1 in the cycle after a dequeue is accepted on a non-empty flow. In that cycle `out_data` holds the word and `out_flow` holds the flow number.
- R9: Bit f of `flow_empty` is 1 exactly when flow f holds no words. An enqueue to the flow clears it, and dequeuing the flow's last word sets it again.
- R10: An enqueue offered while `enq_ready` is 0 is ignored. Its word never appears at the output, and the queue contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | Enqueue can be taken (a free slot exists) |
| enq_flow | input | FLOW_W | Flow number of the enqueue |
| enq_data | input | DATA_W | Word to store |
| deq_valid | input | 1 | Dequeue request |
| deq_ready | output | 1 | Dequeue can be taken (no enqueue competing) |
| deq_flow | input | FLOW_W | Flow number of the dequeue |
| out_valid | output | 1 | Dequeued word present this cycle |
| out_data | output | DATA_W | Dequeued word |
| out_flow | output | FLOW_W | Flow the dequeued word came from |
| deq_err | output | 1 | Previous accepted dequeue targeted an empty flow |
| full | output | 1 | Free stack empty, enqueues refused |
| flow_empty | output | NFLOWS | One bit per flow, 1 when the flow holds no words |

## Verification
The assertions assume that `deq_flow` stays stable from the cycle a dequeue is accepted until its error pulse is judged. They also assume that flow numbers stay below NFLOWS. The bench meets both assumptions: it only ever drives flow numbers 0 to 3, and it changes request fields only on the falling edge, one request per cycle. The bench keeps requesters honest about readiness, with one exception. It offers a single enqueue on purpose while `enq_ready` is 0, to show that the request is dropped.

// File: rtl/qm_pkg.sv
// qm_pkg: shared types for the per-flow queue manager.
// Assumes nothing beyond being compiled before the other qm_* files.
package qm_pkg;

    // Operation taken in a cycle; registered to form the output stage.
    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_ENQ     = 2'd1,
        OP_DEQ     = 2'd2,
        OP_DEQ_ERR = 2'd3
    } qm_op_e;

endpackage

// File: rtl/qm_free_list.sv
// qm_free_list: LIFO stack of slot indices not owned by any flow.
// At reset the first NFLOWS slots belong to the flows (one pre-allocated
// tail each); the stack holds slots NFLOWS..NSLOTS-1.
// Assumes pop and push never occur in the same cycle, and that pop
// happens only when empty is 0.
module qm_free_list #(
    parameter int NSLOTS = 16,
    parameter int NFLOWS = 4,
    localparam int SLOT_W = $clog2(NSLOTS),
    localparam int CNT_W  = $clog2(NSLOTS + 1),
    localparam int FREE0  = NSLOTS - NFLOWS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_slot,
    output logic [SLOT_W-1:0] top_slot,
    output logic              empty
);

    logic [SLOT_W-1:0] stack [NSLOTS];
    logic [CNT_W-1:0]  cnt;

    // Top of stack is the entry just below the fill count.
    always_comb begin
        top_slot = stack[SLOT_W'(cnt - 1'b1)];
        empty    = (cnt == '0);
    end

    // Stack storage and fill count; reset loads the spare slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOTS; i++) begin
                stack[i] <= (i < FREE0) ? SLOT_W'(NFLOWS + i) : '0;
            end
            cnt <= CNT_W'(FREE0);
        end else if (push) begin
            stack[SLOT_W'(cnt)] <= push_slot;
            cnt <= cnt + 1'b1;
        end else if (pop) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/qm_ptr_table.sv
// qm_ptr_table: per-flow head and tail pointers.
// Flow f starts with slot f as both head and tail, which means empty.
// Offers a tail read for the enqueue flow, a head read for the dequeue
// flow, and one emptiness bit per flow.
module qm_ptr_table #(
    parameter int NFLOWS = 4,
    parameter int NSLOTS = 16,
    localparam int SLOT_W = $clog2(NSLOTS),
    localparam int FLOW_W = $clog2(NFLOWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLOW_W-1:0] enq_flow,
    input  logic [FLOW_W-1:0] deq_flow,
    output logic [SLOT_W-1:0] enq_tail,
    output logic [SLOT_W-1:0] deq_head,
    input  logic              tail_we,
    input  logic [SLOT_W-1:0] tail_val,
    input  logic              head_we,
    input  logic [SLOT_W-1:0] head_val,
    output logic [NFLOWS-1:0] flow_empty
);

    logic [SLOT_W-1:0] head [NFLOWS];
    logic [SLOT_W-1:0] tail [NFLOWS];

    // Read ports for the two request channels.
    always_comb begin
        enq_tail = tail[enq_flow];
        deq_head = head[deq_flow];
    end

    // A flow is empty when its head has caught up with its tail.
    for (genvar g = 0; g < NFLOWS; g++) begin : g_empty
        assign flow_empty[g] = (head[g] == tail[g]);
    end

    // Pointer updates; reset gives each flow its own pre-allocated slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NFLOWS; f++) begin
                head[f] <= SLOT_W'(f);
                tail[f] <= SLOT_W'(f);
            end
        end else begin
            if (tail_we) tail[enq_flow] <= tail_val;
            if (head_we) head[deq_flow] <= head_val;
        end
    end

endmodule

// File: rtl/qm_buf_mem.sv
// qm_buf_mem: shared slot storage, each slot a data word plus next link.
// One write port (enqueue) and one asynchronous read port (dequeue).
// Assumes the caller never reads a slot whose contents were not written.
module qm_buf_mem #(
    parameter int NSLOTS = 16,
    parameter int DATA_W = 16,
    localparam int SLOT_W = $clog2(NSLOTS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] wr_next,
    input  logic [SLOT_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SLOT_W-1:0] rd_next
);

    logic [DATA_W-1:0] data_q [NSLOTS];
    logic [SLOT_W-1:0] next_q [NSLOTS];

    // Combinational read of the dequeue slot.
    always_comb begin
        rd_data = data_q[rd_addr];
        rd_next = next_q[rd_addr];
    end

    // Slot write: data and the link to the freshly allocated tail.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_addr] <= wr_data;
            next_q[wr_addr] <= wr_next;
        end
    end

endmodule

// File: rtl/qm_ctrl.sv
// qm_ctrl: request arbitration and the registered output stage.
// Enqueue wins over dequeue; at most one operation per cycle. The chosen
// operation is registered and drives out_valid / deq_err one cycle later.
module qm_ctrl
    import qm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FLOW_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic              deq_valid,
    input  logic [FLOW_W-1:0] deq_flow,
    input  logic              pool_empty,
    input  logic              deq_is_empty,
    input  logic [DATA_W-1:0] rd_data,
    output logic              enq_ready,
    output logic              deq_ready,
    output logic              enq_fire,
    output logic              deq_ok,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [FLOW_W-1:0] out_flow,
    output logic              deq_err
);

    qm_op_e op_d, op_q;

    // Arbitration: the enqueue channel has priority over the dequeue one.
    always_comb begin
        enq_ready = !pool_empty;
        deq_ready = !enq_valid;
        enq_fire  = enq_valid && enq_ready;
        deq_ok    = deq_valid && deq_ready && !deq_is_empty;
        if (enq_fire)                    op_d = OP_ENQ;
        else if (deq_ok)                 op_d = OP_DEQ;
        else if (deq_valid && deq_ready) op_d = OP_DEQ_ERR;
        else                             op_d = OP_NONE;
    end

    // Output stage: last operation plus the captured word and flow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            out_data <= '0;
            out_flow <= '0;
        end else begin
            op_q <= op_d;
            if (deq_ok) begin
                out_data <= rd_data;
                out_flow <= deq_flow;
            end
        end
    end

    // Decode of the registered operation into the status outputs.
    always_comb begin
        out_valid = (op_q == OP_DEQ);
        deq_err   = (op_q == OP_DEQ_ERR);
    end

endmodule

// File: rtl/qm_top.sv
// qm_top: per-flow linked-list queue manager over a shared slot pool.
// Each flow owns a chain of slots from head to a pre-allocated tail.
// Enqueue fills the tail slot and links a new tail popped from the free
// stack; dequeue reads the head slot, follows its link and pushes the
// old head back. Assumes NFLOWS >= 2 and NSLOTS > NFLOWS.
module qm_top #(
    parameter int NFLOWS = 4,
    parameter int NSLOTS = 16,
    parameter int DATA_W = 16,
    localparam int SLOT_W = $clog2(NSLOTS),
    localparam int FLOW_W = $clog2(NFLOWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [FLOW_W-1:0] enq_flow,
    input  logic [DATA_W-1:0] enq_data,
    input  logic              deq_valid,
    output logic              deq_ready,
    input  logic [FLOW_W-1:0] deq_flow,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [FLOW_W-1:0] out_flow,
    output logic              deq_err,
    output logic              full,
    output logic [NFLOWS-1:0] flow_empty
);

    logic              pool_empty;
    logic [SLOT_W-1:0] new_slot;
    logic [SLOT_W-1:0] enq_tail;
    logic [SLOT_W-1:0] deq_head;
    logic [DATA_W-1:0] rd_data;
    logic [SLOT_W-1:0] rd_next;
    logic              enq_fire;
    logic              deq_ok;

    assign full = pool_empty;

    qm_free_list #(.NSLOTS(NSLOTS), .NFLOWS(NFLOWS)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (enq_fire),
        .push      (deq_ok),
        .push_slot (deq_head),
        .top_slot  (new_slot),
        .empty     (pool_empty)
    );

    qm_ptr_table #(.NFLOWS(NFLOWS), .NSLOTS(NSLOTS)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_flow   (enq_flow),
        .deq_flow   (deq_flow),
        .enq_tail   (enq_tail),
        .deq_head   (deq_head),
        .tail_we    (enq_fire),
        .tail_val   (new_slot),
        .head_we    (deq_ok),
        .head_val   (rd_next),
        .flow_empty (flow_empty)
    );

    qm_buf_mem #(.NSLOTS(NSLOTS), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .wr_en   (enq_fire),
        .wr_addr (enq_tail),
        .wr_data (enq_data),
        .wr_next (new_slot),
        .rd_addr (deq_head),
        .rd_data (rd_data),
        .rd_next (rd_next)
    );

    qm_ctrl #(.DATA_W(DATA_W), .FLOW_W(FLOW_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enq_valid    (enq_valid),
        .deq_valid    (deq_valid),
        .deq_flow     (deq_flow),
        .pool_empty   (pool_empty),
        .deq_is_empty (flow_empty[deq_flow]),
        .rd_data      (rd_data),
        .enq_ready    (enq_ready),
        .deq_ready    (deq_ready),
        .enq_fire     (enq_fire),
        .deq_ok       (deq_ok),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_flow     (out_flow),
        .deq_err      (deq_err)
    );

endmodule

// File: rtl/qm_checker.sv
// qm_checker: protocol and timing properties of qm_top, bound to it.
// Assumes deq_flow is held from an accepted dequeue into the next cycle.
module qm_checker #(
    parameter int NFLOWS = 4,
    localparam int FLOW_W = $clog2(NFLOWS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enq_valid,
    input logic              enq_ready,
    input logic              deq_valid,
    input logic              deq_ready,
    input logic [FLOW_W-1:0] deq_flow,
    input logic              out_valid,
    input logic              deq_err,
    input logic              full,
    input logic [NFLOWS-1:0] flow_empty
);

    AST_FULL_BLOCKS_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !enq_ready); // R4

    AST_ENQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |-> !deq_ready); // R7

    AST_OUT_FOLLOWS_DEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && deq_ready && !flow_empty[deq_flow]) |=> out_valid); // R8

    AST_OUT_NEEDS_DEQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(deq_valid && deq_ready)); // R8

    AST_ERR_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && deq_ready && flow_empty[deq_flow]) |=> (deq_err && !out_valid)); // R6

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        deq_err |=> (!deq_err || $past(deq_valid && deq_ready))); // R6

endmodule

bind qm_top qm_checker #(.NFLOWS(NFLOWS)) u_qm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (enq_valid),
    .enq_ready  (enq_ready),
    .deq_valid  (deq_valid),
    .deq_ready  (deq_ready),
    .deq_flow   (deq_flow),
    .out_valid  (out_valid),
    .deq_err    (deq_err),
    .full       (full),
    .flow_empty (flow_empty)
);

// File: tb/test_qm_top.sv
module test_qm_top;

    localparam int NFLOWS = 4;
    localparam int NSLOTS = 16;
    localparam int DATA_W = 16;
    localparam int CAP    = NSLOTS - NFLOWS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enq_valid = 1'b0;
    logic              enq_ready;
    logic [1:0]        enq_flow = '0;
    logic [DATA_W-1:0] enq_data = '0;
    logic              deq_valid = 1'b0;
    logic              deq_ready;
    logic [1:0]        deq_flow = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic [1:0]        out_flow;
    logic              deq_err;
    logic              full;
    logic [NFLOWS-1:0] flow_empty;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    qm_top #(.NFLOWS(NFLOWS), .NSLOTS(NSLOTS), .DATA_W(DATA_W)) i_qm_top (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_flow(enq_flow), .enq_data(enq_data),
        .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_flow(deq_flow),
        .out_valid(out_valid), .out_data(out_data), .out_flow(out_flow),
        .deq_err(deq_err), .full(full), .flow_empty(flow_empty)
    );

    // expect: 0 = nothing out, 1 = word out, 2 = error pulse
    typedef struct packed {
        logic        is_deq;
        logic [1:0]  flow;
        logic [15:0] data;
        logic [1:0]  expect_kind;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b0, 2'd0, 16'h0011, 2'd0},
        '{1'b0, 2'd0, 16'h0012, 2'd0},
        '{1'b0, 2'd1, 16'h0021, 2'd0},
        '{1'b1, 2'd0, 16'h0011, 2'd1},
        '{1'b0, 2'd2, 16'h0031, 2'd0},
        '{1'b1, 2'd1, 16'h0021, 2'd1},
        '{1'b1, 2'd0, 16'h0012, 2'd1},
        '{1'b1, 2'd0, 16'h0000, 2'd2},
        '{1'b1, 2'd2, 16'h0031, 2'd1},
        '{1'b0, 2'd3, 16'h0041, 2'd0},
        '{1'b0, 2'd3, 16'h0042, 2'd0},
        '{1'b1, 2'd3, 16'h0041, 2'd1},
        '{1'b1, 2'd3, 16'h0042, 2'd1},
        '{1'b1, 2'd1, 16'h0000, 2'd2}
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One request for one cycle; outputs sampled on the following falling edge.
    task automatic do_op(input logic is_deq, input logic [1:0] flow,
                         input logic [DATA_W-1:0] data);
        @(negedge clk);
        if (is_deq) begin
            deq_valid = 1'b1; deq_flow = flow;
        end else begin
            enq_valid = 1'b1; enq_flow = flow; enq_data = data;
        end
        @(negedge clk);
        enq_valid = 1'b0;
        deq_valid = 1'b0;
    endtask

    task automatic expect_word(input string req, input logic [1:0] flow,
                               input logic [DATA_W-1:0] data);
        check(out_valid && out_data == data && out_flow == flow && !deq_err, req,
              {out_valid, 5'd0, out_flow, out_data}, {1'b1, 5'd0, flow, data});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(flow_empty == '1 && !full && enq_ready && !out_valid && !deq_err, "R1",
              {flow_empty, full, enq_ready, out_valid, deq_err}, {4'hF, 4'b0100});

        // R2 R3 R6 R8: vector walk over interleaved flows
        for (int i = 0; i < 14; i++) begin
            do_op(VECS[i].is_deq, VECS[i].flow, VECS[i].data);
            case (VECS[i].expect_kind)
                2'd1: expect_word("R2/R3/R8 vector", VECS[i].flow, VECS[i].data);
                2'd2: check(deq_err && !out_valid, "R6 empty dequeue",
                            {deq_err, out_valid}, 2'b10);
                default: check(!out_valid && !deq_err, "R8 no output on enqueue",
                               {out_valid, deq_err}, 2'b00);
            endcase
        end
        check(flow_empty == '1, "R9 all drained", flow_empty, 4'hF);

        // R4: fill the pool through flow 2
        for (int k = 0; k < CAP; k++) begin
            check(enq_ready, "R4 ready before capacity", enq_ready, 1);
            do_op(1'b0, 2'd2, DATA_W'(16'h0080 + k));
        end
        check(full && !enq_ready, "R4 full at capacity", {full, enq_ready}, 2'b10);
        check(flow_empty == 4'b1011, "R9 flow 2 not empty", flow_empty, 4'b1011);

        // R10: enqueue offered while full is dropped
        do_op(1'b0, 2'd1, 16'h00EE);
        check(flow_empty == 4'b1011 && full, "R10 refused enqueue",
              {flow_empty, full}, {4'b1011, 1'b1});

        // R5: one dequeue frees a slot
        do_op(1'b1, 2'd2, '0);
        expect_word("R2 first of full queue", 2'd2, 16'h0080);
        check(!full && enq_ready, "R5 slot returned", {full, enq_ready}, 2'b01);
        do_op(1'b0, 2'd2, 16'h0099);
        check(full, "R5 refill accepted", full, 1);

        // R2: drain in order
        for (int k = 1; k < CAP; k++) begin
            do_op(1'b1, 2'd2, '0);
            expect_word("R2 drain order", 2'd2, DATA_W'(16'h0080 + k));
        end
        do_op(1'b1, 2'd2, '0);
        expect_word("R10 last word is the accepted one", 2'd2, 16'h0099);
        check(flow_empty == '1, "R9 empty after drain", flow_empty, 4'hF);

        // R7: simultaneous requests, enqueue wins
        @(negedge clk);
        enq_valid = 1'b1; enq_flow = 2'd1; enq_data = 16'h0055;
        deq_valid = 1'b1; deq_flow = 2'd1;
        #1;
        check(!deq_ready, "R7 dequeue held off", deq_ready, 0);
        @(negedge clk);
        enq_valid = 1'b0;
        check(!out_valid && !deq_err && flow_empty[1] == 1'b0, "R7 only enqueue taken",
              {out_valid, deq_err, flow_empty[1]}, 3'b000);
        @(negedge clk);
        deq_valid = 1'b0;
        expect_word("R8 held dequeue completes", 2'd1, 16'h0055);
        @(negedge clk);
        check(!out_valid && !deq_err, "R8 single-cycle pulse", {out_valid, deq_err}, 2'b00);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule